// File: doc/BRIEF.md
# Serialized frequent-value bus codec

This block carries wide data words across a link with half as many data lines as the word has bits. A transmitter splits each accepted word into two half-word beats, low half first, and the link moves beats at twice the word rate, so a steady stream still delivers one word every two link cycles. A receiver at the far end puts the two halves back together and presents the word on a valid/ready output.

To cut line toggling, each end keeps two small tables of recently seen half-word values. One table serves low halves and the other serves high halves. When a half is found in its table, the transmitter sends a one-hot code that names the entry instead of the value. When it is not found, the raw half is sent and both ends insert it into the same slot. Beats are sent as transitions: the lines carry the running XOR of every beat payload, so a table hit flips exactly one line. A sideband line tells the receiver whether a beat is a code or a raw value. Both ends use the same least-recently-used rule to update their tables, so the tables stay identical.

Top module: `fv_serial_codec`

## Requirements
- R1: After reset, out_valid, link_valid, link_hot and every link line are 0, and in_ready is 1.
- R2: Every accepted word appears on out_data exactly once, unchanged and in the order it was accepted.
- R3: A word crosses the link as two beats. The low half (bits W-1:0) goes first and the high half (bits 2W-1:W) goes second.
- R4: When a half matches a valid entry of its table, the beat has link_hot = 1. The link lines then differ from the previously taken beat in exactly one line, and that line's position is the entry index.
- R5: When a half matches no entry, the beat has link_hot = 0, and the link lines equal the previous lines XOR the raw half.
- R6: Each table follows least-recently-used order. A miss writes the new value into the lowest-numbered invalid entry or, when the table is full, into the least recently used entry. A hit makes the matched entry the most recently used.
- R7: After reset every table entry is invalid, so the first beats after reset are raw, even for the value 0.
- R8: With out_ready held at 1 and in_valid held at 1, a word is accepted every second cycle, and in_ready is 0 in the cycle after each accept.
- R9: With nothing else in flight, out_valid rises 3 link cycles after the accepting clock edge, which is within 2 word periods.
- R10: While out_valid is 1 and out_ready is 0, out_valid and out_data hold, and no word is lost or overwritten.
- R11: A low half is looked up only in the low table and a high half only in the high table. A value that is held only in the other table produces a raw beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, twice the word rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word accepted on this edge when in_valid is 1 |
| in_data | input | 2*W | Word to send |
| out_valid | output | 1 | Reassembled word available |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 2*W | Reassembled word |
| link_lines | output | W | Transition-coded beat lines between the two ends |
| link_hot | output | 1 | Sideband: 1 for a table code, 0 for a raw half |
| link_valid | output | 1 | A beat is on the link |

## Verification
The bench builds the codec with W = 4, which gives 8-bit words and 4-entry tables. At that size every one of the 256 words can be swept, and the tables fill within a few words, so full-table eviction under least-recently-used order happens often. Each beat on the link is compared with a model of both tables. The model predicts whether the beat is a hit and which line must flip. Backpressure is toggled from a pseudo-random stream, so the high beat and the output stall at many different points.

// File: rtl/fv_serial_codec.sv
module fv_serial_codec #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [2*W-1:0] in_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2*W-1:0] out_data,
  output logic [W-1:0]   link_lines,
  output logic           link_hot,
  output logic           link_valid
);
  localparam int AW = $clog2(W);
  localparam int NT = 4;

  logic         tx_ph, rx_ph, lnk_vld, lnk_hot, out_v;
  logic         take, adv, tx_fire;
  logic [W-1:0] hi_hold, lnk, rx_prev, lo_hold;
  logic [W-1:0] tx_half, tx_hit, pay, rx_pay, rx_val;
  logic [2*W-1:0] out_q;
  logic [W-1:0] rdv [2];

  assign take     = lnk_vld & (~rx_ph | ~out_v | out_ready);
  assign adv      = ~lnk_vld | take;
  assign in_ready = ~tx_ph & adv;
  assign tx_fire  = adv & (tx_ph | in_valid);
  assign tx_half  = tx_ph ? hi_hold : in_data[W-1:0];
  assign rx_pay   = lnk ^ rx_prev;
  assign rx_val   = lnk_hot ? (rx_ph ? rdv[1] : rdv[0]) : rx_pay;

  for (genvar t = 0; t < NT; t++) begin : g_tab
    logic [W-1:0]  val [W];
    logic [AW-1:0] age [W];
    logic [W-1:0]  vld, hit, vic, kk;
    logic [AW-1:0] hage;
    logic          any, we, seen;

    assign kk = (t == 0) ? in_data[W-1:0] : (t == 1) ? hi_hold : rx_val;
    assign we = (t == 0) ? (tx_fire & ~tx_ph) :
                (t == 1) ? (tx_fire & tx_ph) :
                (t == 2) ? (take & ~rx_ph) : (take & rx_ph);

    always_comb begin
      hit  = '0;
      vic  = '0;
      hage = '0;
      seen = 1'b0;
      for (int i = 0; i < W; i++) begin
        hit[i] = vld[i] && (val[i] == kk);
        if (hit[i]) hage = hage | age[i];
        if (!vld[i] && !seen) begin
          vic[i] = 1'b1;
          seen   = 1'b1;
        end
      end
      if (!seen)
        for (int i = 0; i < W; i++)
          if (age[i] == AW'(W - 1)) vic[i] = 1'b1;
    end

    assign any = |hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld <= '0;
        for (int i = 0; i < W; i++) begin
          val[i] <= '0;
          age[i] <= '0;
        end
      end else if (we) begin
        for (int i = 0; i < W; i++) begin
          if (any) begin
            if (hit[i]) age[i] <= '0;
            else if (vld[i] && age[i] < hage) age[i] <= age[i] + 1'b1;
          end else if (vic[i]) begin
            val[i] <= kk;
            vld[i] <= 1'b1;
            age[i] <= '0;
          end else if (vld[i]) begin
            age[i] <= age[i] + 1'b1;
          end
        end
      end
    end

    if (t >= 2) begin : g_rd
      logic [W-1:0] rd;
      always_comb begin
        rd = '0;
        for (int i = 0; i < W; i++)
          if (rx_pay[i]) rd = rd | val[i];
      end
      assign rdv[t-2] = rd;
    end
  end

  assign tx_hit = tx_ph ? g_tab[1].hit : g_tab[0].hit;
  assign pay    = (|tx_hit) ? tx_hit : tx_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ph   <= 1'b0;
      hi_hold <= '0;
      lnk     <= '0;
      lnk_hot <= 1'b0;
      lnk_vld <= 1'b0;
    end else if (tx_fire) begin
      lnk     <= lnk ^ pay;
      lnk_hot <= |tx_hit;
      lnk_vld <= 1'b1;
      tx_ph   <= ~tx_ph;
      if (!tx_ph) hi_hold <= in_data[2*W-1:W];
    end else if (take) begin
      lnk_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ph   <= 1'b0;
      rx_prev <= '0;
      lo_hold <= '0;
      out_q   <= '0;
      out_v   <= 1'b0;
    end else begin
      if (take) begin
        rx_prev <= lnk;
        rx_ph   <= ~rx_ph;
        if (!rx_ph) lo_hold <= rx_val;
        else        out_q   <= {rx_val, lo_hold};
      end
      if (take && rx_ph)  out_v <= 1'b1;
      else if (out_ready) out_v <= 1'b0;
    end
  end

  assign out_valid  = out_v;
  assign out_data   = out_q;
  assign link_lines = lnk;
  assign link_hot   = lnk_hot;
  assign link_valid = lnk_vld;
endmodule

// File: rtl/fv_serial_codec_chk.sv
module fv_serial_codec_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [2*W-1:0] out_data,
  input logic           link_valid,
  input logic           link_hot,
  input logic           take,
  input logic [W-1:0]   link_lines
);
  logic [W-1:0] last_lines;
  logic         seen_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_lines <= '0;
      seen_raw   <= 1'b0;
    end else if (take) begin
      last_lines <= link_lines;
      if (!link_hot) seen_raw <= 1'b1;
    end
  end

  assert_one_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid && link_hot |-> $countones(link_lines ^ last_lines) == 1);

  assert_hot_after_raw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid && link_hot |-> seen_raw);

  assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

bind fv_serial_codec fv_serial_codec_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .link_valid(link_valid), .link_hot(link_hot), .take(take),
  .link_lines(link_lines)
);

// File: tb/test_fv_serial_codec.sv
module test_fv_serial_codec;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [2*W-1:0] in_data = '0;
  logic in_ready, out_valid, link_hot, link_valid;
  logic [2*W-1:0] out_data;
  logic [W-1:0] link_lines;

  always #4 clk = ~clk;

  fv_serial_codec #(.W(W)) i_fv_serial_codec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .link_lines(link_lines), .link_hot(link_hot),
    .link_valid(link_valid)
  );

  int checks = 0, fails = 0, cyc = 0;
  int wr = 0, rd = 0, bi = 0, bph = 0, hidx;
  logic [7:0] sent [0:4095];
  int acc_t [0:4095];
  logic [3:0] prev_lines = '0, half, pl;
  logic [3:0] mval [2][4];
  bit mvld [2][4];
  int mage [2][4];
  bit last_hot [2];
  bit stall_prev = 0, bp_mode = 0;
  logic [7:0] stall_data;
  logic [31:0] seed = 32'h1234_5678, bseed = 32'h0bad_cafe;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task m_lookup(input int t, input logic [3:0] v, output int idx);
    idx = -1;
    for (int i = 0; i < 4; i++) if (mvld[t][i] && mval[t][i] == v) idx = i;
  endtask

  task m_update(input int t, input logic [3:0] v, input int idx);
    int h, vic;
    if (idx >= 0) begin
      h = mage[t][idx];
      for (int i = 0; i < 4; i++)
        if (i == idx) mage[t][i] = 0;
        else if (mvld[t][i] && mage[t][i] < h) mage[t][i]++;
    end else begin
      vic = -1;
      for (int i = 3; i >= 0; i--) if (!mvld[t][i]) vic = i;
      if (vic < 0) for (int i = 0; i < 4; i++) if (mage[t][i] == 3) vic = i;
      for (int i = 0; i < 4; i++)
        if (i == vic) begin mval[t][i] = v; mvld[t][i] = 1; mage[t][i] = 0; end
        else if (mvld[t][i]) mage[t][i]++;
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (in_valid && in_ready) begin
        sent[wr] = in_data;
        acc_t[wr] = cyc;
        wr++;
      end
      if (link_valid && (bph == 0 || !out_valid || out_ready)) begin
        half = (bph == 1) ? sent[bi][7:4] : sent[bi][3:0];
        pl = link_lines ^ prev_lines;
        m_lookup(bph, half, hidx);
        if (hidx >= 0) begin
          check(link_hot == 1'b1, "R4 hit beat kind", link_hot, 1);
          check(pl == 4'(1 << hidx), "R6 hot line index", pl, 1 << hidx);
        end else begin
          check(link_hot == 1'b0, "R5 miss beat kind", link_hot, 0);
          check(pl == half, "R5 raw payload in R3 beat order", pl, half);
        end
        last_hot[bph] = link_hot;
        m_update(bph, half, hidx);
        prev_lines = link_lines;
        if (bph == 1) bi++;
        bph ^= 1;
      end
      if (stall_prev)
        check(out_valid && out_data == stall_data, "R10 output hold", out_data, stall_data);
      if (out_valid && out_ready) begin
        check(out_data == sent[rd], "R2 delivered word", out_data, sent[rd]);
        rd++;
      end
      stall_prev = out_valid && !out_ready;
      stall_data = out_data;
    end
  end

  always @(negedge clk) if (bp_mode) begin
    bseed = bseed * 32'd1103515245 + 32'd12345;
    out_ready <= bseed[17] | bseed[9];
  end

  task automatic drive(input logic [7:0] w);
    in_valid = 1'b1;
    in_data = w;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int t0, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1
    check(!out_valid && !link_valid && !link_hot && link_lines == 0, "R1 reset outputs",
          {out_valid, link_valid, link_hot, link_lines}, 0);
    check(in_ready == 1'b1, "R1 reset in_ready", in_ready, 1);
    out_ready = 1'b1;
    @(negedge clk);

    // R7: empty tables, value 0 must go raw
    drive(8'h00); in_valid = 1'b0; #1;
    check(link_valid && !link_hot && link_lines == 0, "R7 first low beat raw",
          {link_valid, link_hot, link_lines}, 6'h20);
    @(negedge clk); #1;
    check(link_valid && !link_hot && link_lines == 0, "R7 first high beat raw",
          {link_valid, link_hot, link_lines}, 6'h20);
    idle(4);
    // R3: low half first, then high half
    drive(8'hA5); in_valid = 1'b0; #1;
    check(link_lines == 4'h5, "R3 low beat first", link_lines, 4'h5);
    @(negedge clk); #1;
    check(link_lines == 4'hF, "R3 high beat second", link_lines, 4'hF);
    idle(4);
    drive(8'h00); idle(4);
    check(last_hot[0] && last_hot[1], "R4 repeated word hits", {last_hot[0], last_hot[1]}, 3);
    // R11: 5 is only in low table, A only in high table
    drive(8'h55); idle(4);
    check(last_hot[0] == 1 && last_hot[1] == 0, "R11 low-only value", {last_hot[0], last_hot[1]}, 2);
    drive(8'hAA); idle(4);
    check(last_hot[0] == 0 && last_hot[1] == 1, "R11 high-only value", {last_hot[0], last_hot[1]}, 1);

    // R9 latency
    idle(4);
    drive(8'h3C); in_valid = 1'b0;
    t0 = acc_t[wr-1];
    n = 0;
    while (!out_valid && n < 10) begin @(negedge clk); #1; n++; end
    check(cyc - t0 == 3, "R9 latency", cyc - t0, 3);
    idle(4);

    // R8 throughput
    t0 = wr;
    for (int k = 0; k < 20; k++) begin
      drive(8'(k * 37));
      check(!in_ready, "R8 in_ready low after accept", in_ready, 0);
    end
    idle(6);
    check(acc_t[t0 + 19] - acc_t[t0] == 38, "R8 accept spacing", acc_t[t0 + 19] - acc_t[t0], 38);

    // R2 exhaustive word sweep
    for (int k = 0; k < 256; k++) drive(8'(k));
    idle(6);

    // R6 LRU: cyclic patterns that fill and evict
    for (int k = 0; k < 200; k++) drive({4'(k % 3), 4'(k % 5)});
    idle(6);

    // R10 backpressure with a narrow alphabet
    bp_mode = 1;
    for (int k = 0; k < 600; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      drive({1'b0, seed[26:24], 1'b0, seed[18:16]});
    end
    in_valid = 1'b0;
    bp_mode = 0;
    @(negedge clk);
    out_ready = 1'b1;
    idle(10);
    check(rd == wr, "R2 all words delivered", rd, wr);
    check(!out_valid, "R2 output drained", out_valid, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule